// File: doc/BRIEF.md
# Prioritized Memory Access Permission Checker

This block decides whether a single memory access may proceed. A request carries a byte address, a byte count, the set of requested read, write and execute rights and the privilege level of the requester. The block compares the access against a table of protection entries. Each entry supplies an inclusive lower and upper byte bound, a configuration byte and a lock flag, and the table also supplies a count of the entries that are in use. The block returns one allow or deny verdict per request.

Entries are searched in fixed priority order, with index 0 first. The block checks both the first and the last byte of the access against each entry. An access that lies only partly inside an entry is refused. An access that lies wholly inside an enabled entry takes its rights from that entry. Machine mode skips the rights check unless the entry is locked. When no entry decides the verdict, the privilege level sets the default. An access length of zero means "up to the end of the page". An access whose last byte would pass the top of the address space is refused.

The request is registered on entry to the block, and the verdict is formed from that register against the table as it stands at that moment. An optional output register adds one more cycle. The table is expected to be stable while a request is in flight.

Top module: `perm_checker`

## Requirements
- R1: When `active_cnt` is zero, every access is allowed, except the overflow case of R10.
- R2: Entries are examined from index 0 upward, and the lowest-indexed entry that decides the verdict fixes it. Later entries are ignored even if they would grant the access.
- R3: The first byte is `req_addr` and the last byte is `req_addr + length - 1`. A byte is inside an entry when it satisfies lower <= byte <= upper, with both bounds inclusive.
- R4: If exactly one of the first and last bytes is inside an entry, that entry decides the verdict as deny, whatever its match mode.
- R5: An entry is enabled when config bits [4:3] are not 00. An enabled entry that holds both bytes decides the verdict. For a requester whose `req_priv` is not 2'b11, the access is allowed only if every requested right is present in config bits [0] (read), [1] (write) and [2] (execute). `req_perm` uses the same bit order.
- R6: For a machine-mode requester (`req_priv` = 2'b11), an enabled entry that holds the access grants all rights unless the entry is locked. An entry is locked when config bit [7] is set or its `ent_lock` bit is set. A locked entry applies the check of R5.
- R7: An entry with config bits [4:3] = 00 that holds both bytes does not decide the verdict, and the search goes on to the next entry.
- R8: With `active_cnt` non-zero and no deciding entry, a machine-mode access is allowed and any other access is denied.
- R9: A `req_size` of zero gives a length that runs from `req_addr` to the last byte of its PAGE_BYTES-aligned page.
- R10: If the last byte computed without wrap-around exceeds the top address, the access is denied. This takes precedence over every other rule.
- R11: `rsp_valid` is high for exactly one cycle, one cycle after `req_valid` is sampled high, or two cycles after it when OUT_REG = 1. At other times it is low.
- R12: During and directly after reset, `rsp_valid` and `rsp_allow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | First byte address of the access |
| req_size | input | SIZE_W | Access length in bytes; 0 means to the end of the page |
| req_perm | input | 3 | Requested rights: bit 0 read, bit 1 write, bit 2 execute |
| req_priv | input | 2 | Requester privilege level; 2'b11 is machine mode |
| ent_lo | input | NUM_ENT*ADDR_W | Inclusive lower byte bound per entry, entry i at bits [i*ADDR_W +: ADDR_W] |
| ent_hi | input | NUM_ENT*ADDR_W | Inclusive upper byte bound per entry, same packing |
| ent_cfg | input | NUM_ENT*8 | Config byte per entry: [2:0] rights, [4:3] match mode, [7] lock |
| ent_lock | input | NUM_ENT | Lock flag per entry, supplied by the table logic |
| active_cnt | input | CNT_W | Number of entries in use |
| rsp_valid | output | 1 | Verdict strobe |
| rsp_allow | output | 1 | 1 = access allowed; meaningful while rsp_valid is high |

## Verification
Several rules can bear on the same request, and the bench targets the cases where they meet. A partial overlap in a low entry can coincide with full containment in a higher entry that would grant the access. Machine-mode bypass can coincide with a lock, and the no-match default can coincide with an overflowing length. Directed requests place the first or last byte exactly on a bound, or straddle the bound, while overlapping entries disagree on rights. Constrained random tables and addresses clustered around the bounds then mix these cases freely. Every verdict is compared with a bench model that evaluates the rules in priority order.

// File: rtl/perm_checker_pkg.sv
package perm_checker_pkg;
    localparam logic [1:0] PRIV_MACHINE = 2'b11;
    localparam int CFG_RD_BIT   = 0;
    localparam int CFG_WR_BIT   = 1;
    localparam int CFG_EX_BIT   = 2;
    localparam int CFG_MODE_LSB = 3;
    localparam int CFG_MODE_MSB = 4;
    localparam int CFG_LOCK_BIT = 7;
endpackage

// File: rtl/perm_span_calc.sv
module perm_span_calc #(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 13,
    parameter int PAGE_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic [ADDR_W-1:0] last,
    output logic              overflow
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int WIDE_W = ADDR_W + 1;

    logic [WIDE_W-1:0] len_w;
    logic [WIDE_W-1:0] end_w;
    logic [WIDE_W-1:0] page_off_w;

    always_comb begin
        page_off_w = WIDE_W'(addr[PAGE_W-1:0]);
        if (size == '0) begin
            len_w = WIDE_W'(PAGE_BYTES) - page_off_w;
        end else begin
            len_w = WIDE_W'(size);
        end
        end_w    = {1'b0, addr} + len_w - WIDE_W'(1);
        last     = end_w[ADDR_W-1:0];
        overflow = end_w[ADDR_W];
    end
endmodule

// File: rtl/perm_entry_match.sv
module perm_entry_match
    import perm_checker_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic [7:0]        cfg,
    input  logic              lock_in,
    input  logic [ADDR_W-1:0] first_byte,
    input  logic [ADDR_W-1:0] last_byte,
    input  logic [1:0]        priv,
    input  logic [2:0]        perm,
    output logic              decides,
    output logic              grants,
    output logic              partial,
    output logic              full_hit
);
    logic first_in;
    logic last_in;
    logic enabled;
    logic locked;
    logic restricted;
    logic [2:0] rights;

    always_comb begin
        first_in   = (first_byte >= lo) && (first_byte <= hi);
        last_in    = (last_byte >= lo) && (last_byte <= hi);
        enabled    = cfg[CFG_MODE_MSB:CFG_MODE_LSB] != 2'b00;
        locked     = lock_in | cfg[CFG_LOCK_BIT];
        rights     = {cfg[CFG_EX_BIT], cfg[CFG_WR_BIT], cfg[CFG_RD_BIT]};
        restricted = (priv != PRIV_MACHINE) || locked;
        partial    = first_in ^ last_in;
        full_hit   = first_in && last_in && enabled;
        decides    = partial || full_hit;
        if (partial) begin
            grants = 1'b0;
        end else if (restricted) begin
            grants = (perm & ~rights) == 3'b000;
        end else begin
            grants = 1'b1;
        end
    end
endmodule

// File: rtl/perm_priority_resolve.sv
module perm_priority_resolve
    import perm_checker_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int CNT_W   = 4
) (
    input  logic [NUM_ENT-1:0] decides,
    input  logic [NUM_ENT-1:0] grants,
    input  logic [CNT_W-1:0]   active_cnt,
    input  logic               overflow,
    input  logic [1:0]         priv,
    output logic               any_hit,
    output logic               allow
);
    logic found;
    logic picked;

    always_comb begin
        found  = 1'b0;
        picked = (priv == PRIV_MACHINE);
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!found && decides[i]) begin
                found  = 1'b1;
                picked = grants[i];
            end
        end
        any_hit = found;
        if (overflow) begin
            allow = 1'b0;
        end else if (active_cnt == '0) begin
            allow = 1'b1;
        end else begin
            allow = picked;
        end
    end
endmodule

// File: rtl/perm_checker.sv
module perm_checker
    import perm_checker_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 13,
    parameter int NUM_ENT    = 8,
    parameter int PAGE_BYTES = 4096,
    parameter bit OUT_REG    = 1'b0,
    parameter int CNT_W      = $clog2(NUM_ENT + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [SIZE_W-1:0]         req_size,
    input  logic [2:0]                req_perm,
    input  logic [1:0]                req_priv,
    input  logic [NUM_ENT*ADDR_W-1:0] ent_lo,
    input  logic [NUM_ENT*ADDR_W-1:0] ent_hi,
    input  logic [NUM_ENT*8-1:0]      ent_cfg,
    input  logic [NUM_ENT-1:0]        ent_lock,
    input  logic [CNT_W-1:0]          active_cnt,
    output logic                      rsp_valid,
    output logic                      rsp_allow
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] last;
        logic              overflow;
        logic [2:0]        perm;
        logic [1:0]        priv;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [ADDR_W-1:0]  span_last;
    logic               span_ovf;
    logic [NUM_ENT-1:0] ent_decides;
    logic [NUM_ENT-1:0] ent_grants;
    logic [NUM_ENT-1:0] ent_partial;
    logic [NUM_ENT-1:0] ent_full;
    logic               any_hit;
    logic               verdict;

    perm_span_calc #(
        .ADDR_W    (ADDR_W),
        .SIZE_W    (SIZE_W),
        .PAGE_BYTES(PAGE_BYTES)
    ) span_i (
        .addr    (req_addr),
        .size    (req_size),
        .last    (span_last),
        .overflow(span_ovf)
    );

    always_comb begin
        stage_d          = stage_q;
        stage_d.valid    = req_valid;
        if (req_valid) begin
            stage_d.addr     = req_addr;
            stage_d.last     = span_last;
            stage_d.overflow = span_ovf;
            stage_d.perm     = req_perm;
            stage_d.priv     = req_priv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_entry
        perm_entry_match #(
            .ADDR_W(ADDR_W)
        ) match_i (
            .lo        (ent_lo[g*ADDR_W +: ADDR_W]),
            .hi        (ent_hi[g*ADDR_W +: ADDR_W]),
            .cfg       (ent_cfg[g*8 +: 8]),
            .lock_in   (ent_lock[g]),
            .first_byte(stage_q.addr),
            .last_byte (stage_q.last),
            .priv      (stage_q.priv),
            .perm      (stage_q.perm),
            .decides   (ent_decides[g]),
            .grants    (ent_grants[g]),
            .partial   (ent_partial[g]),
            .full_hit  (ent_full[g])
        );
    end

    perm_priority_resolve #(
        .NUM_ENT(NUM_ENT),
        .CNT_W  (CNT_W)
    ) resolve_i (
        .decides   (ent_decides),
        .grants    (ent_grants),
        .active_cnt(active_cnt),
        .overflow  (stage_q.overflow),
        .priv      (stage_q.priv),
        .any_hit   (any_hit),
        .allow     (verdict)
    );

    if (OUT_REG) begin : g_outreg
        typedef struct packed {
            logic valid;
            logic allow;
        } out_t;
        out_t out_d, out_q;

        always_comb begin
            out_d.valid = stage_q.valid;
            out_d.allow = stage_q.valid && verdict;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q <= '0;
            end else begin
                out_q <= out_d;
            end
        end

        assign rsp_valid = out_q.valid;
        assign rsp_allow = out_q.allow;

        assert_rsp_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid == $past(req_valid, 2));
    end else begin : g_direct
        assign rsp_valid = stage_q.valid;
        assign rsp_allow = stage_q.valid && verdict;

        assert_rsp_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid == $past(req_valid));
    end

    assert_zero_rules_allow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q.valid && active_cnt == '0 && !stage_q.overflow) |-> verdict);

    assert_first_partial_deny_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q.valid && active_cnt != '0 && ent_partial[0]) |-> !verdict);

    assert_machine_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q.valid && active_cnt != '0 && !stage_q.overflow && ent_full[0]
         && stage_q.priv == PRIV_MACHINE && !ent_lock[0] && !ent_cfg[CFG_LOCK_BIT])
        |-> verdict);

    assert_nomatch_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q.valid && active_cnt != '0 && !stage_q.overflow && !any_hit)
        |-> (verdict == (stage_q.priv == PRIV_MACHINE)));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q.valid && stage_q.overflow) |-> !verdict);
endmodule

// File: tb/perm_checker_tb_top.sv
module perm_checker_tb_top;
    localparam int AW = 32;
    localparam int SW = 13;
    localparam int NE = 8;
    localparam int PG = 4096;
    localparam bit OREG = 1'b0;
    localparam int CW = $clog2(NE + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [SW-1:0] req_size = '0;
    logic [2:0] req_perm = '0;
    logic [1:0] req_priv = '0;
    logic [NE*AW-1:0] ent_lo;
    logic [NE*AW-1:0] ent_hi;
    logic [NE*8-1:0] ent_cfg;
    logic [NE-1:0] ent_lock = '0;
    logic [CW-1:0] active_cnt = '0;
    logic rsp_valid;
    logic rsp_allow;

    logic [AW-1:0] t_lo [NE];
    logic [AW-1:0] t_hi [NE];
    logic [7:0] t_cfg [NE];

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NE; i++) begin
            ent_lo[i*AW +: AW] = t_lo[i];
            ent_hi[i*AW +: AW] = t_hi[i];
            ent_cfg[i*8 +: 8]  = t_cfg[i];
        end
    end

    perm_checker #(
        .ADDR_W(AW), .SIZE_W(SW), .NUM_ENT(NE), .PAGE_BYTES(PG), .OUT_REG(OREG)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_perm(req_perm), .req_priv(req_priv),
        .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_cfg(ent_cfg), .ent_lock(ent_lock),
        .active_cnt(active_cnt), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow)
    );

    function automatic bit model(logic [AW-1:0] a, logic [SW-1:0] sz,
                                 logic [2:0] pm, logic [1:0] pv);
        longint unsigned len, last, fa;
        bit fi, li, restr;
        fa = longint'(a);
        if (sz == 0) len = PG - (fa % PG);
        else len = longint'(sz);
        last = fa + len - 1;
        if (last > 64'hFFFF_FFFF) return 1'b0;
        if (active_cnt == 0) return 1'b1;
        for (int i = 0; i < NE; i++) begin
            fi = (fa >= t_lo[i]) && (fa <= t_hi[i]);
            li = (last >= t_lo[i]) && (last <= t_hi[i]);
            if (fi != li) return 1'b0;
            if (fi && li && t_cfg[i][4:3] != 2'b00) begin
                restr = (pv != 2'b11) || ent_lock[i] || t_cfg[i][7];
                if (!restr) return 1'b1;
                return (pm & ~t_cfg[i][2:0]) == 3'b000;
            end
        end
        return pv == 2'b11;
    endfunction

    task automatic check(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
        end
    endtask

    task automatic run_req(logic [AW-1:0] a, logic [SW-1:0] sz, logic [2:0] pm,
                           logic [1:0] pv, output logic v, output logic al);
        @(negedge clk);
        req_addr = a; req_size = sz; req_perm = pm; req_priv = pv; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (int'(OREG)) @(negedge clk);
        v = rsp_valid;
        al = rsp_allow;
    endtask

    task automatic exp_req(string tag, logic [AW-1:0] a, logic [SW-1:0] sz,
                           logic [2:0] pm, logic [1:0] pv, logic exp);
        logic v, al;
        run_req(a, sz, pm, pv, v, al);
        check({tag, " valid"}, v, 1'b1);
        check(tag, al, exp);
        check({tag, " model"}, exp, model(a, sz, pm, pv));
    endtask

    task automatic clear_table();
        for (int i = 0; i < NE; i++) begin
            t_lo[i] = 32'hF000_0000; t_hi[i] = 32'hF000_0000; t_cfg[i] = 8'h00;
        end
        ent_lock = '0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic v, al;
        clear_table();
        repeat (3) @(negedge clk);
        check("R12 reset valid", rsp_valid, 1'b0);
        check("R12 reset allow", rsp_allow, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 post-reset valid", rsp_valid, 1'b0);

        active_cnt = 0;
        exp_req("R1 zero rules user write", 32'h0000_5000, 13'd8, 3'b010, 2'b00, 1'b1);
        exp_req("R10 overflow zero rules", 32'hFFFF_FFFE, 13'd4, 3'b001, 2'b11, 1'b0);
        exp_req("R10 top edge fits", 32'hFFFF_FFFE, 13'd2, 3'b001, 2'b00, 1'b1);

        t_lo[0] = 32'h1000; t_hi[0] = 32'h1FFF; t_cfg[0] = 8'h09;
        t_lo[1] = 32'h1000; t_hi[1] = 32'h3FFF; t_cfg[1] = 8'h0B;
        active_cnt = 2;
        exp_req("R5 user read entry0", 32'h1100, 13'd4, 3'b001, 2'b00, 1'b1);
        exp_req("R2 entry0 denies write first", 32'h1100, 13'd4, 3'b010, 2'b01, 1'b0);
        exp_req("R2 entry1 grants write", 32'h2100, 13'd4, 3'b010, 2'b00, 1'b1);
        exp_req("R5 exec not granted", 32'h2100, 13'd4, 3'b100, 2'b00, 1'b0);
        exp_req("R4 partial entry0", 32'h1FFE, 13'd4, 3'b001, 2'b00, 1'b0);
        exp_req("R3 upper bound inclusive", 32'h1FFC, 13'd4, 3'b001, 2'b00, 1'b1);
        exp_req("R3 lower bound inclusive", 32'h1000, 13'd1, 3'b001, 2'b00, 1'b1);
        exp_req("R6 machine bypass", 32'h1100, 13'd4, 3'b110, 2'b11, 1'b1);
        ent_lock[0] = 1'b1;
        exp_req("R6 machine lock input", 32'h1100, 13'd4, 3'b010, 2'b11, 1'b0);
        exp_req("R6 machine lock read ok", 32'h1100, 13'd4, 3'b001, 2'b11, 1'b1);
        ent_lock[0] = 1'b0; t_cfg[0] = 8'h89;
        exp_req("R6 machine cfg lock", 32'h1100, 13'd4, 3'b010, 2'b11, 1'b0);
        t_cfg[0] = 8'h09;
        exp_req("R8 nomatch machine", 32'h8000, 13'd4, 3'b111, 2'b11, 1'b1);
        exp_req("R8 nomatch user", 32'h8000, 13'd4, 3'b001, 2'b00, 1'b0);
        t_cfg[0] = 8'h01;
        exp_req("R7 off entry skipped", 32'h1100, 13'd4, 3'b010, 2'b00, 1'b1);
        t_lo[2] = 32'h0; t_hi[2] = 32'h0FFF; t_cfg[2] = 8'h00;
        exp_req("R4 partial on off entry", 32'h0FFE, 13'd4, 3'b001, 2'b11, 1'b0);
        t_lo[2] = 32'hF000_0000; t_hi[2] = 32'hF000_0000;
        exp_req("R9 size zero to page end", 32'h3F00, 13'd0, 3'b001, 2'b00, 1'b1);
        t_hi[1] = 32'h3FFE;
        exp_req("R9 size zero straddles bound", 32'h3F00, 13'd0, 3'b001, 2'b00, 1'b0);
        exp_req("R9 short access fits", 32'h3F00, 13'd4, 3'b001, 2'b00, 1'b1);
        exp_req("R10 overflow with rules", 32'hFFFF_FFF0, 13'd32, 3'b001, 2'b11, 1'b0);

        run_req(32'h1100, 13'd4, 3'b001, 2'b00, v, al);
        check("R11 strobe present", v, 1'b1);
        @(negedge clk);
        check("R11 strobe single cycle", rsp_valid, 1'b0);

        void'($urandom(32'h5EED));
        for (int b = 0; b < 60; b++) begin
            clear_table();
            for (int i = 0; i < NE; i++) begin
                t_lo[i] = 32'h1000 + ($urandom % 16) * 32'h200;
                t_hi[i] = t_lo[i] + ($urandom % 32'h1000);
                t_cfg[i] = 8'($urandom);
                if ($urandom % 4 == 0) t_cfg[i][4:3] = 2'b00;
                if ($urandom % 6 != 0) t_cfg[i][7] = 1'b0;
            end
            ent_lock = NE'($urandom) & NE'($urandom) & NE'($urandom);
            active_cnt = CW'(($urandom % 5 == 0) ? 0 : 1 + ($urandom % NE));
            for (int k = 0; k < 30; k++) begin
                logic [AW-1:0] a;
                logic [SW-1:0] sz;
                logic [2:0] pm;
                logic [1:0] pv;
                int j;
                j = int'($urandom % NE);
                case ($urandom % 4)
                    0: a = t_lo[j] - ($urandom % 8);
                    1: a = t_hi[j] - ($urandom % 8);
                    2: a = 32'hFFFF_FFC0 + ($urandom % 64);
                    default: a = 32'h0800 + ($urandom % 32'h4000);
                endcase
                sz = ($urandom % 8 == 0) ? '0 : SW'(1 + ($urandom % 64));
                pm = 3'($urandom);
                pv = 2'($urandom);
                run_req(a, sz, pm, pv, v, al);
                check("R11 random valid", v, 1'b1);
                check("R2 random verdict", al, model(a, sz, pm, pv));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule